// File: doc/BRIEF.md
# Programmable Flag Offset Sequencer

This block sits beside a FIFO core and holds the two thresholds that drive the FIFO's almost-empty and almost-full flags. The thresholds live in four byte-wide registers: the low and high bytes of the empty threshold, and the low and high bytes of the full threshold. They are loaded from the FIFO data input bus and read back on a dedicated readback bus. A single rotating selector steps through the four registers in a fixed order. The selector keeps its position when a burst of loads or reads stops part way, so software can update one byte at a time.

Programmable-flag mode is chosen while reset is held. If the load-select pin is low during reset, loading, readback and both flags are live. If it is high during reset, the block stays passive: it ignores load and read requests and holds both flags inactive (high).

The write side runs on the write clock. The read side runs on the read clock. The two clocks may be unrelated or the same. The block has no valid/ready stream: loads and readbacks are single-beat strobes sampled on each clock edge. Neither side can apply back-pressure, so software paces its own accesses.

Top module: `pf_offset_seq`

## Requirements
- R1: In programmable-flag mode, every write-clock edge with `load_sel_n`=0 and `wr_en_n`=0 stores `wr_data` into the currently selected register. The selection then advances in the order 0 empty-low byte, 1 empty-high byte, 2 full-low byte, 3 full-high byte.
- R2: After the full-high byte (selection 3), the next load writes the empty-low byte again.
- R3: An edge that does not load leaves the write selection unchanged. A burst that stops after some registers continues with the next register in order when loading resumes.
- R4: In programmable-flag mode, every read-clock edge with `load_sel_n`=0, `rd_en_a_n`=0 and `rd_en_b_n`=0 registers the selected offset byte onto `rb_data`. The read selection advances through the same order and wraps the same way. Any other read-clock edge leaves `rb_data` unchanged.
- R5: These write-clock cases leave all offset registers unchanged:
  - `load_sel_n`=0 with `wr_en_n`=1 (idle);
  - `load_sel_n`=1 with `wr_en_n`=0 (a normal FIFO write, owned by the core);
  - both pins high.
- R6: Reset (`rst_n`=0, sampled on each clock) has these effects:
  - the empty and full thresholds both return to 7 (low bytes 7, high bytes 0);
  - both selections return to 0;
  - `rb_data` clears to 0;
  - `ae_n` goes low and `af_n` goes high.
- R7: In programmable-flag mode, `ae_n` is registered on the read clock. It is 0 when `rd_fill` ≤ the empty threshold, and 1 otherwise.
- R8: In programmable-flag mode, `af_n` is registered on the write clock. It is 0 when (2^ADDR_W − `wr_fill`) ≤ the full threshold, and 1 otherwise.
- R9: A threshold is the high byte concatenated with the low byte, using only its ADDR_W low bits. High-byte bits at and above ADDR_W−8 are not stored and read back as 0 (with ADDR_W=10, only high-byte bits 1:0 remain).
- R10: If `load_sel_n` is 1 during reset, the block is in plain mode until the next reset:
  - load and readback requests have no effect;
  - `rb_data` keeps its value;
  - `ae_n` and `af_n` both stay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled by both clocks |
| load_sel_n | input | 1 | Active-low offset access select; sampled during reset to pick the mode |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en_a_n | input | 1 | First active-low read enable |
| rd_en_b_n | input | 1 | Second active-low read enable |
| wr_data | input | 8 | FIFO data input bus, used as the load byte |
| wr_fill | input | ADDR_W+1 | FIFO fill count in the write-clock domain |
| rd_fill | input | ADDR_W+1 | FIFO fill count in the read-clock domain |
| rb_data | output | 8 | Offset readback byte |
| ae_n | output | 1 | Almost-empty flag, active low |
| af_n | output | 1 | Almost-full flag, active low |

## Verification
The assertions assume these conditions on the inputs:
- the fill counts never exceed 2^ADDR_W;
- software never loads and reads back the offset registers on the same clock edge;
- the clocks are running while reset is held.

The stimulus drives both clock ports from one clock and never asserts a load and a readback in the same vector. It keeps every fill value between 0 and 2^ADDR_W. Expected readback bytes and flag levels come from a small model of the selection order and the two comparisons. That model is updated only after the edge that consumes each vector.

// File: rtl/pf_offset_pkg.sv
package pf_offset_pkg;

  // Fixed selection order; the order is behaviour, so the encoding is kept.
  typedef enum logic [1:0] {
    SEL_E_LO = 2'd0,
    SEL_E_HI = 2'd1,
    SEL_F_LO = 2'd2,
    SEL_F_HI = 2'd3
  } pf_sel_e;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned DEF_LO    = 7;

  function automatic pf_sel_e pf_next_sel(input pf_sel_e cur);
    return pf_sel_e'(cur + 2'd1);
  endfunction

endpackage

// File: rtl/pf_offset_bank.sv
module pf_offset_bank
  import pf_offset_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned HI_W  = ADDR_W - BYTE_W
) (
  input  logic               wclk,
  input  logic               rst_n,
  input  logic               load_sel_n,
  input  logic               wr_en_n,
  input  logic [BYTE_W-1:0]  wr_data,
  output logic               prog_mode,
  output logic [BYTE_W-1:0]  e_lo,
  output logic [HI_W-1:0]    e_hi,
  output logic [BYTE_W-1:0]  f_lo,
  output logic [HI_W-1:0]    f_hi
);

  pf_sel_e wsel_q;
  logic    load_hit;

  assign load_hit = prog_mode && !load_sel_n && !wr_en_n;

  always_ff @(posedge wclk) begin
    if (!rst_n) begin
      prog_mode <= !load_sel_n;
      wsel_q    <= SEL_E_LO;
      e_lo      <= BYTE_W'(DEF_LO);
      e_hi      <= '0;
      f_lo      <= BYTE_W'(DEF_LO);
      f_hi      <= '0;
    end else if (load_hit) begin
      wsel_q <= pf_next_sel(wsel_q);
      unique case (wsel_q)
        SEL_E_LO: e_lo <= wr_data;
        SEL_E_HI: e_hi <= wr_data[HI_W-1:0];
        SEL_F_LO: f_lo <= wr_data;
        SEL_F_HI: f_hi <= wr_data[HI_W-1:0];
        default:  e_lo <= wr_data;
      endcase
    end
  end

  // R3
  hold_sel_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !load_hit |=> $stable(wsel_q));

  // R5
  no_load_stable_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (load_sel_n || wr_en_n) |=> ($stable(e_lo) && $stable(e_hi) && $stable(f_lo) && $stable(f_hi)));

  // R10
  plain_mode_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !prog_mode |=> ($stable(wsel_q) && $stable(e_lo) && $stable(f_lo)));

  // R1
  step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    load_hit |=> (wsel_q != $past(wsel_q)));

endmodule

// File: rtl/pf_offset_readback.sv
module pf_offset_readback
  import pf_offset_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned HI_W  = ADDR_W - BYTE_W
) (
  input  logic               rclk,
  input  logic               rst_n,
  input  logic               load_sel_n,
  input  logic               rd_en_a_n,
  input  logic               rd_en_b_n,
  input  logic [BYTE_W-1:0]  e_lo,
  input  logic [HI_W-1:0]    e_hi,
  input  logic [BYTE_W-1:0]  f_lo,
  input  logic [HI_W-1:0]    f_hi,
  output logic               prog_mode,
  output logic [BYTE_W-1:0]  rb_data
);

  pf_sel_e           rsel_q;
  logic              rd_hit;
  logic [BYTE_W-1:0] pick;

  assign rd_hit = prog_mode && !load_sel_n && !rd_en_a_n && !rd_en_b_n;

  always_comb begin
    unique case (rsel_q)
      SEL_E_LO: pick = e_lo;
      SEL_E_HI: pick = {{(BYTE_W-HI_W){1'b0}}, e_hi};
      SEL_F_LO: pick = f_lo;
      SEL_F_HI: pick = {{(BYTE_W-HI_W){1'b0}}, f_hi};
      default:  pick = e_lo;
    endcase
  end

  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      prog_mode <= !load_sel_n;
      rsel_q    <= SEL_E_LO;
      rb_data   <= '0;
    end else if (rd_hit) begin
      rsel_q  <= pf_next_sel(rsel_q);
      rb_data <= pick;
    end
  end

  // R4
  rb_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    !rd_hit |=> $stable(rb_data));

  // R9
  hi_zero_chk: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_hit && rsel_q[0]) |=> (rb_data[BYTE_W-1:HI_W] == '0));

endmodule

// File: rtl/pf_flag_cmp.sv
module pf_flag_cmp #(
  parameter int unsigned ADDR_W    = 10,
  parameter bit          FULL_SIDE = 1'b0,
  localparam int unsigned CNT_W    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_mode,
  input  logic [CNT_W-1:0]  fill,
  input  logic [ADDR_W-1:0] thresh,
  output logic              flag_n
);

  localparam logic [CNT_W-1:0] DEPTH = CNT_W'(1) << ADDR_W;
  localparam logic             RST_V = FULL_SIDE;

  logic [CNT_W-1:0] metric;

  generate
    if (FULL_SIDE) begin : g_free
      assign metric = DEPTH - fill;
    end else begin : g_used
      assign metric = fill;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)         flag_n <= RST_V;
    else if (!prog_mode) flag_n <= 1'b1;
    else                 flag_n <= !(metric <= {1'b0, thresh});
  end

  // R10
  plain_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_mode |=> flag_n);

  // R7 / R8
  fill_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= DEPTH);

endmodule

// File: rtl/pf_offset_seq.sv
module pf_offset_seq
  import pf_offset_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  localparam int unsigned CNT_W = ADDR_W + 1,
  localparam int unsigned HI_W  = ADDR_W - BYTE_W
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              load_sel_n,
  input  logic              wr_en_n,
  input  logic              rd_en_a_n,
  input  logic              rd_en_b_n,
  input  logic [7:0]        wr_data,
  input  logic [CNT_W-1:0]  wr_fill,
  input  logic [CNT_W-1:0]  rd_fill,
  output logic [7:0]        rb_data,
  output logic              ae_n,
  output logic              af_n
);

  logic              wmode, rmode;
  logic [BYTE_W-1:0] e_lo, f_lo;
  logic [HI_W-1:0]   e_hi, f_hi;

  pf_offset_bank #(.ADDR_W(ADDR_W)) bank_i (
    .wclk(wclk), .rst_n(rst_n), .load_sel_n(load_sel_n), .wr_en_n(wr_en_n),
    .wr_data(wr_data), .prog_mode(wmode),
    .e_lo(e_lo), .e_hi(e_hi), .f_lo(f_lo), .f_hi(f_hi)
  );

  pf_offset_readback #(.ADDR_W(ADDR_W)) rdbk_i (
    .rclk(rclk), .rst_n(rst_n), .load_sel_n(load_sel_n),
    .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n),
    .e_lo(e_lo), .e_hi(e_hi), .f_lo(f_lo), .f_hi(f_hi),
    .prog_mode(rmode), .rb_data(rb_data)
  );

  pf_flag_cmp #(.ADDR_W(ADDR_W), .FULL_SIDE(1'b0)) ae_i (
    .clk(rclk), .rst_n(rst_n), .prog_mode(rmode), .fill(rd_fill),
    .thresh({e_hi, e_lo}), .flag_n(ae_n)
  );

  pf_flag_cmp #(.ADDR_W(ADDR_W), .FULL_SIDE(1'b1)) af_i (
    .clk(wclk), .rst_n(rst_n), .prog_mode(wmode), .fill(wr_fill),
    .thresh({f_hi, f_lo}), .flag_n(af_n)
  );

  // R1 / R4: offset load and readback never on the same write edge
  no_overlap_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !(!load_sel_n && !wr_en_n && !rd_en_a_n && !rd_en_b_n));

endmodule

// File: tb/pf_offset_seq_tb.sv
module pf_offset_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 10;
  localparam int CNT_W      = ADDR_W + 1;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int NV         = 25;

  // {req[3:0], load_n, wen_n, ren_n, data[7:0], fill[10:0]}
  localparam logic [25:0] VECS [NV] = '{
    {4'd1, 1'b0,1'b0,1'b1, 8'h03, 11'd0},     // R1 empty low
    {4'd1, 1'b0,1'b0,1'b1, 8'h01, 11'd0},     // R1 empty high
    {4'd5, 1'b1,1'b0,1'b1, 8'hAA, 11'd0},     // R5 normal write
    {4'd5, 1'b0,1'b1,1'b1, 8'h55, 11'd0},     // R5 idle
    {4'd5, 1'b1,1'b1,1'b1, 8'h66, 11'd0},     // R5 idle
    {4'd1, 1'b0,1'b0,1'b1, 8'h10, 11'd0},     // R1 full low
    {4'd9, 1'b0,1'b0,1'b1, 8'hFF, 11'd0},     // R9 full high masked
    {4'd2, 1'b0,1'b0,1'b1, 8'h05, 11'd0},     // R2 wrap
    {4'd4, 1'b0,1'b1,1'b0, 8'h00, 11'd0},     // R4
    {4'd4, 1'b0,1'b1,1'b0, 8'h00, 11'd0},
    {4'd4, 1'b0,1'b1,1'b0, 8'h00, 11'd0},
    {4'd9, 1'b0,1'b1,1'b0, 8'h00, 11'd0},     // R9 high bits zero
    {4'd4, 1'b0,1'b1,1'b0, 8'h00, 11'd0},     // R4 wrap
    {4'd7, 1'b1,1'b1,1'b1, 8'h00, 11'd261},   // R7
    {4'd7, 1'b1,1'b1,1'b1, 8'h00, 11'd262},
    {4'd8, 1'b1,1'b1,1'b1, 8'h00, 11'd240},   // R8
    {4'd8, 1'b1,1'b1,1'b1, 8'h00, 11'd239},
    {4'd8, 1'b1,1'b1,1'b1, 8'h00, 11'd1024},
    {4'd3, 1'b0,1'b0,1'b1, 8'h02, 11'd0},     // R3 partial burst
    {4'd3, 1'b1,1'b1,1'b1, 8'h00, 11'd0},
    {4'd3, 1'b0,1'b0,1'b1, 8'h20, 11'd0},
    {4'd3, 1'b0,1'b1,1'b0, 8'h00, 11'd0},
    {4'd3, 1'b0,1'b1,1'b0, 8'h00, 11'd0},
    {4'd7, 1'b1,1'b1,1'b1, 8'h00, 11'd517},
    {4'd7, 1'b1,1'b1,1'b1, 8'h00, 11'd518}
  };

  logic clk = 1'b0;
  logic rst_n, load_sel_n, wr_en_n, rd_en_n;
  logic [7:0] wr_data;
  logic [CNT_W-1:0] fill;
  logic [7:0] rb_data;
  logic ae_n, af_n;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_reg [4];
  int m_wp, m_rp;
  logic [7:0] m_rb;
  bit m_prog;

  always #(CLK_PERIOD/2) clk = ~clk;

  pf_offset_seq #(.ADDR_W(ADDR_W)) dut_i (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .load_sel_n(load_sel_n),
    .wr_en_n(wr_en_n), .rd_en_a_n(rd_en_n), .rd_en_b_n(rd_en_n),
    .wr_data(wr_data), .wr_fill(fill), .rd_fill(fill),
    .rb_data(rb_data), .ae_n(ae_n), .af_n(af_n)
  );

  task automatic check(input int req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode_pin);
    @(negedge clk);
    rst_n = 1'b0; load_sel_n = mode_pin; wr_en_n = 1'b1; rd_en_n = 1'b1;
    wr_data = '0; fill = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    m_prog = !mode_pin;
    m_reg[0] = 8'd7; m_reg[1] = 8'd0; m_reg[2] = 8'd7; m_reg[3] = 8'd0;
    m_wp = 0; m_rp = 0; m_rb = 8'd0;
    check(6, "reset rb_data", rb_data, 0);
    check(6, "reset ae_n", ae_n, 0);
    check(6, "reset af_n", af_n, 1);
    rst_n = 1'b1; load_sel_n = 1'b1;
  endtask

  // Applies one vector at a negedge, checks at the following negedge.
  task automatic step(input int req, input logic ld, input logic we, input logic re,
                      input logic [7:0] d, input logic [CNT_W-1:0] f);
    int eoff, foff, exp_ae, exp_af;
    load_sel_n = ld; wr_en_n = we; rd_en_n = re; wr_data = d; fill = f;
    eoff = {m_reg[1][1:0], m_reg[0]};
    foff = {m_reg[3][1:0], m_reg[2]};
    exp_ae = m_prog ? int'(!(int'(f) <= eoff)) : 1;
    exp_af = m_prog ? int'(!((DEPTH - int'(f)) <= foff)) : 1;
    @(posedge clk);
    if (m_prog && !ld && !re) begin
      m_rb = m_reg[m_rp]; m_rp = (m_rp + 1) % 4;
    end
    if (m_prog && !ld && !we) begin
      m_reg[m_wp] = (m_wp % 2 == 1) ? (d & 8'h03) : d; m_wp = (m_wp + 1) % 4;
    end
    @(negedge clk);
    check(req, "rb_data", rb_data, m_rb);
    check(req, "ae_n", ae_n, exp_ae);
    check(req, "af_n", af_n, exp_af);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; load_sel_n = 1'b0; wr_en_n = 1'b1; rd_en_n = 1'b1;
    wr_data = '0; fill = '0;
    do_reset(1'b0);
    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VECS[i];
      step(int'(v[25:22]), v[21], v[20], v[19], v[18:11], v[10:0]);
    end

    // R10: plain mode ignores loads and reads, flags inactive
    do_reset(1'b1);
    step(10, 1'b0, 1'b0, 1'b1, 8'h44, 11'd0);
    step(10, 1'b0, 1'b1, 1'b0, 8'h00, 11'd0);
    step(10, 1'b1, 1'b1, 1'b1, 8'h00, 11'd1024);

    // R6: defaults visible through readback after a programmable reset
    do_reset(1'b0);
    for (int k = 0; k < 4; k++) step(6, 1'b0, 1'b1, 1'b0, 8'h00, 11'd0);
    step(7, 1'b1, 1'b1, 1'b1, 8'h00, 11'd7);     // R7 default edge
    step(7, 1'b1, 1'b1, 1'b1, 8'h00, 11'd8);
    step(8, 1'b1, 1'b1, 1'b1, 8'h00, 11'd1017);  // R8 default edge
    step(8, 1'b1, 1'b1, 1'b1, 8'h00, 11'd1016);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule